// File: doc/BRIEF.md
# Stack Pointer and Call/Return Sequencer

This block owns the processor's stack pointer and turns stack requests into accesses on a single-port internal data RAM. It handles six operations: push one byte, pop one byte, call, return, interrupt return, and a direct load of the pointer. A call saves a multi-byte return address. A return recovers that address and hands it to the program-counter logic on a dedicated output. An interrupt return does the same work and also sends a one-cycle pulse that frees the active interrupt priority level.

The pointer always names the most recently stored stack byte. Stores increment it before writing, and reads use the current address and then decrement it. The RAM has a registered read port, so read data returns one clock after the address is presented. The block takes one request at a time. It raises a one-cycle completion strobe when the request has finished. Any request that arrives before that strobe is dropped.

Top module: `stack_call_unit`

## Requirements
- R1: During and after a synchronous reset the pointer reads 8'h07, and the completion strobe, the release pulse and the RAM write enable are all low.
- R2: A push (request bit 0) first increments the pointer and then writes the input byte at the new pointer address.
- R3: A pop (request bit 1) reads the byte at the pointer address and then decrements the pointer; the byte appears on the popped-byte output in the cycle the completion strobe is high.
- R4: A call (request bit 2) stores the low byte of the return address at pointer+1 and the high byte at pointer+2, and leaves the pointer raised by two.
- R5: A return (request bit 3) reads the high byte at the pointer address and then the low byte at pointer-1, leaves the pointer lowered by two, and shows the rebuilt 16-bit address on the return-address output together with the completion strobe.
- R6: An interrupt return (request bit 4) behaves exactly like R5 and also drives the release pulse high for exactly the one cycle the completion strobe is high; no other operation produces that pulse.
- R7: A load (request bit 5) replaces the pointer with the load input value and performs no RAM access.
- R8: Pointer arithmetic wraps modulo 256 in both directions, and no error is flagged.
- R9: When a request is accepted at clock edge E, each of its n bytes occupies the RAM port for one cycle, starting in the cycle after E. The completion strobe is a single-cycle pulse that becomes visible after edge E+n+1, where n is 1 for push and pop, 2 for call and both returns, and 0 for load.
- R10: A request is accepted only if exactly one of the six request bits is set and no operation is in progress. The done cycle is not counted as in progress. A rejected request leaves the pointer and the RAM port untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 6 | One-hot request: bit0 push, bit1 pop, bit2 call, bit3 return, bit4 interrupt return, bit5 load |
| push_byte | input | 8 | Byte stored by a push |
| call_ret_addr | input | 16 | Return address saved by a call |
| load_val | input | 8 | New pointer value for a load |
| sp | output | 8 | Current stack pointer |
| ram_addr | output | 8 | Internal RAM address |
| ram_wdata | output | 8 | Internal RAM write data |
| ram_we | output | 1 | Internal RAM write enable |
| ram_rdata | input | 8 | Internal RAM read data, one clock after the address |
| pop_byte | output | 8 | Last byte read from the stack |
| ret_addr | output | 16 | Return address rebuilt by the last return |
| done | output | 1 | One-cycle completion strobe |
| prio_release | output | 1 | One-cycle priority-level release pulse |

## Verification
Every result of this block appears at a known edge after acceptance. The pointer changes and each RAM access begin at the acceptance edge E and at each later edge that starts a further byte. The completion strobe, the popped byte, the rebuilt return address and the release pulse all appear together after edge E+n+1. When the bench accepts a request, its model writes every expected access, pointer value and done edge into tables indexed by edge number. Halfway through each cycle the bench compares all outputs against the entry for the edge just passed. Requests sent while an operation is still running, or with more than one request bit set, have no entry in those tables, so any effect they have on the pointer or the RAM port is reported.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OP_W    = 6;
  localparam int OP_PUSH = 0;
  localparam int OP_POP  = 1;
  localparam int OP_CALL = 2;
  localparam int OP_RET  = 3;
  localparam int OP_RETI = 4;
  localparam int OP_LOAD = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } stk_state_t;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SPW = 8,
  parameter logic [SPW-1:0] SP_RST = 8'h07
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inc,
  input  logic           dec,
  input  logic           ld,
  input  logic [SPW-1:0] ld_val,
  output logic [SPW-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (rst)      sp_q <= SP_RST;
    else if (ld)  sp_q <= ld_val;
    else if (inc) sp_q <= sp_q + 1'b1;
    else if (dec) sp_q <= sp_q - 1'b1;
  end

  // R1: reset value
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> sp_q == SP_RST);

  // R8: without a load the pointer moves by at most one, wrapping freely
  assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (sp_q == $past(sp_q)) || (sp_q == $past(sp_q) + 1'b1)
            || (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SPW = 8,
  parameter int NB  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_req,
  input  logic [DW-1:0]   push_byte,
  input  logic [NB*DW-1:0] call_addr,
  input  logic [SPW-1:0]  sp_q,
  output logic            sp_inc,
  output logic            sp_dec,
  output logic            sp_ld,
  output logic [SPW-1:0]  ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic            rd_valid,
  output logic            done,
  output logic            prio_rel
);
  localparam int IW = $clog2(NB + 1);

  stk_state_t       state_q;
  logic [OP_W-1:0]  op_q;
  logic [NB*DW-1:0] call_q;
  logic [IW-1:0]    cnt_q, idx_q;
  logic [SPW-1:0]   addr_q;
  logic [DW-1:0]    wdata_q;
  logic             we_q, rd_iss_q, rd_val_q, done_q, prio_q;

  logic [DW-1:0] call_bytes [NB];
  for (genvar g = 0; g < NB; g++) begin : g_split
    assign call_bytes[g] = call_q[g*DW +: DW];
  end

  logic [DW-1:0] next_byte;
  always_comb begin
    next_byte = '0;
    for (int i = 0; i < NB; i++)
      if (idx_q == IW'(i)) next_byte = call_bytes[i];
  end

  logic [OP_W-1:0] cur_op;
  logic cur_wr, req_ok, accept, issue, multi;
  assign cur_op = (state_q == ST_IDLE) ? op_req : op_q;
  assign cur_wr = cur_op[OP_PUSH] | cur_op[OP_CALL];
  assign req_ok = (op_req != '0) && ((op_req & (op_req - 1'b1)) == '0);
  assign accept = (state_q == ST_IDLE) && req_ok;
  assign multi  = op_req[OP_CALL] | op_req[OP_RET] | op_req[OP_RETI];
  assign issue  = (accept && !op_req[OP_LOAD]) ||
                  (state_q == ST_XFER && cnt_q != '0);
  assign sp_inc = issue && cur_wr;
  assign sp_dec = issue && !cur_wr;
  assign sp_ld  = accept && op_req[OP_LOAD];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      call_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      rd_iss_q <= 1'b0;
      rd_val_q <= 1'b0;
      done_q   <= 1'b0;
      prio_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      prio_q   <= 1'b0;
      rd_val_q <= rd_iss_q;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q   <= op_req;
          call_q <= call_addr;
          if (op_req[OP_LOAD]) begin
            state_q <= ST_FIN;
          end else begin
            state_q  <= ST_XFER;
            cnt_q    <= multi ? IW'(NB - 1) : '0;
            idx_q    <= IW'(1);
            addr_q   <= cur_wr ? sp_q + 1'b1 : sp_q;
            wdata_q  <= op_req[OP_PUSH] ? push_byte : call_addr[DW-1:0];
            we_q     <= cur_wr;
            rd_iss_q <= !cur_wr;
          end
        end
        ST_XFER: begin
          if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
            idx_q   <= idx_q + 1'b1;
            addr_q  <= cur_wr ? sp_q + 1'b1 : sp_q;
            wdata_q <= next_byte;
          end else begin
            we_q     <= 1'b0;
            rd_iss_q <= 1'b0;
            state_q  <= ST_FIN;
          end
        end
        default: begin
          done_q  <= 1'b1;
          prio_q  <= op_q[OP_RETI];
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign ram_we    = we_q;
  assign rd_valid  = rd_val_q;
  assign done      = done_q;
  assign prio_rel  = prio_q;

  // R2, R4: every write lands at the address the pointer now holds
  assert_write_at_sp_R2: assert property (@(posedge clk) disable iff (rst)
    we_q |-> addr_q == sp_q);
  // R3, R5: every read targets the slot just above the lowered pointer
  assert_read_above_sp_R5: assert property (@(posedge clk) disable iff (rst)
    rd_iss_q |-> addr_q == sp_q + 1'b1);
  // R6: release pulse only together with completion
  assert_release_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    prio_q |-> done_q);
  // R9: completion strobe lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R10: completion only when a new request may be taken
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> state_q == ST_IDLE);
endmodule

// File: rtl/stk_unpack.sv
module stk_unpack #(
  parameter int DW = 8,
  parameter int NB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rdata,
  output logic [NB*DW-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (rst)           cap_q <= '0;
    else if (rd_valid) cap_q <= {cap_q[NB*DW-DW-1:0], rdata};
  end
endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
  import stk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SPW = 8,
  parameter int PCW = 16,
  parameter logic [SPW-1:0] SP_RST = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_req,
  input  logic [DW-1:0]   push_byte,
  input  logic [PCW-1:0]  call_ret_addr,
  input  logic [SPW-1:0]  load_val,
  output logic [SPW-1:0]  sp,
  output logic [SPW-1:0]  ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  input  logic [DW-1:0]   ram_rdata,
  output logic [DW-1:0]   pop_byte,
  output logic [PCW-1:0]  ret_addr,
  output logic            done,
  output logic            prio_release
);
  localparam int NB = PCW / DW;

  logic sp_inc, sp_dec, sp_ld, rd_valid;
  logic [PCW-1:0] cap;

  stk_ptr #(.SPW(SPW), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst(rst), .inc(sp_inc), .dec(sp_dec), .ld(sp_ld),
    .ld_val(load_val), .sp_q(sp)
  );

  stk_ctrl #(.DW(DW), .SPW(SPW), .NB(NB)) u_ctrl (
    .clk(clk), .rst(rst), .op_req(op_req), .push_byte(push_byte),
    .call_addr(call_ret_addr), .sp_q(sp), .sp_inc(sp_inc), .sp_dec(sp_dec),
    .sp_ld(sp_ld), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .rd_valid(rd_valid), .done(done), .prio_rel(prio_release)
  );

  stk_unpack #(.DW(DW), .NB(NB)) u_unpack (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rdata(ram_rdata), .cap_q(cap)
  );

  assign pop_byte = cap[DW-1:0];
  assign ret_addr = cap;
endmodule

// File: tb/sim_stack_call_unit.sv
`timescale 1ns/1ps
module sim_stack_call_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [5:0]  op_req;
  logic [7:0]  push_byte, load_val, sp, ram_addr, ram_wdata, ram_rdata, pop_byte;
  logic [15:0] call_ret_addr, ret_addr;
  logic        ram_we, done, prio_release;

  stack_call_unit u0 (
    .clk(clk), .rst(rst), .op_req(op_req), .push_byte(push_byte),
    .call_ret_addr(call_ret_addr), .load_val(load_val), .sp(sp),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .pop_byte(pop_byte), .ret_addr(ret_addr),
    .done(done), .prio_release(prio_release)
  );

  // environment RAM, registered read
  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    ram_rdata <= ram[ram_addr];
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: schedules keyed by edge number
  int cyc = 0;
  int done_edge = -1, busy_end = 0;
  logic [7:0] mm [256];
  logic [7:0] m_sp, m_vis;
  logic [7:0] wr_addr [int];
  logic [7:0] wr_data [int];
  logic [7:0] rd_addr [int];
  logic [7:0] sp_at [int];
  logic [7:0] exp_pop;
  logic [15:0] exp_ret;
  int m_kind = -1;
  string m_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_sp = 8'h07; m_vis = 8'h07; busy_end = cyc; done_edge = -1; m_kind = -1;
      m_tag = "R1";
    end else begin
      if (cyc > busy_end && $onehot(op_req)) begin
        int n = 0;
        if (op_req[0]) begin
          m_sp = m_sp + 1'b1; wr_addr[cyc] = m_sp; wr_data[cyc] = push_byte;
          mm[m_sp] = push_byte; sp_at[cyc] = m_sp; n = 1; m_kind = 0; m_tag = "R2";
        end else if (op_req[1]) begin
          rd_addr[cyc] = m_sp; exp_pop = mm[m_sp]; m_sp = m_sp - 1'b1;
          sp_at[cyc] = m_sp; n = 1; m_kind = 1; m_tag = "R3";
        end else if (op_req[2]) begin
          for (int i = 0; i < 2; i++) begin
            m_sp = m_sp + 1'b1; wr_addr[cyc+i] = m_sp;
            wr_data[cyc+i] = call_ret_addr[i*8 +: 8];
            mm[m_sp] = call_ret_addr[i*8 +: 8]; sp_at[cyc+i] = m_sp;
          end
          n = 2; m_kind = 2; m_tag = "R4";
        end else if (op_req[3] || op_req[4]) begin
          exp_ret[15:8] = mm[m_sp]; rd_addr[cyc] = m_sp; m_sp = m_sp - 1'b1;
          sp_at[cyc] = m_sp;
          exp_ret[7:0] = mm[m_sp]; rd_addr[cyc+1] = m_sp; m_sp = m_sp - 1'b1;
          sp_at[cyc+1] = m_sp;
          n = 2; m_kind = op_req[4] ? 4 : 3; m_tag = op_req[4] ? "R6" : "R5";
        end else begin
          m_sp = load_val; sp_at[cyc] = m_sp; n = 0; m_kind = 5; m_tag = "R7";
        end
        done_edge = cyc + n + 1;
        busy_end = done_edge;
      end else if (op_req != 6'd0) begin
        m_tag = "R10";
      end
      if (sp_at.exists(cyc)) m_vis = sp_at[cyc];
    end
  end

  always @(negedge clk) begin
    if (!rst && cyc > 0 && !finished) begin
      bit dn;
      chk(sp === m_vis, {m_tag, " pointer"}, sp, m_vis);
      if (wr_addr.exists(cyc))
        chk(ram_we === 1'b1 && ram_addr === wr_addr[cyc] && ram_wdata === wr_data[cyc],
            {m_tag, " write access"}, {ram_we, ram_addr, ram_wdata},
            {1'b1, wr_addr[cyc], wr_data[cyc]});
      else if (rd_addr.exists(cyc))
        chk(ram_we === 1'b0 && ram_addr === rd_addr[cyc], {m_tag, " read access"},
            {ram_we, ram_addr}, {1'b0, rd_addr[cyc]});
      else
        chk(ram_we === 1'b0, {m_tag, " no write"}, ram_we, 0);
      dn = (cyc == done_edge);
      chk(done === dn, "R9 done timing", done, dn);
      chk(prio_release === (dn && m_kind == 4), "R6 release pulse", prio_release,
          dn && m_kind == 4);
      if (dn && m_kind == 1) chk(pop_byte === exp_pop, "R3 popped byte", pop_byte, exp_pop);
      if (dn && (m_kind == 3 || m_kind == 4))
        chk(ret_addr === exp_ret, {m_tag, " return address"}, ret_addr, exp_ret);
    end
  end

  task automatic send(logic [5:0] op, logic [7:0] b, logic [15:0] a, logic [7:0] v);
    op_req = op; push_byte = b; call_ret_addr = a; load_val = v;
    @(negedge clk);
    op_req = 6'd0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; mm[i] = 8'h00; end
    rst = 1'b1; op_req = 6'd0; push_byte = 8'h00; call_ret_addr = 16'h0; load_val = 8'h00;
    gap(3);
    chk(sp === 8'h07 && done === 1'b0 && prio_release === 1'b0 && ram_we === 1'b0,
        "R1 reset state", {sp, done, prio_release, ram_we}, {8'h07, 3'b000});
    rst = 1'b0;
    gap(1);
    send(6'b000001, 8'hA1, 16'h0, 8'h0); gap(3);
    send(6'b000001, 8'hB2, 16'h0, 8'h0); gap(3);
    chk(sp === 8'h09, "R2 two pushes", sp, 8'h09);
    send(6'b000100, 8'h0, 16'h1234, 8'h0); gap(4);
    chk(sp === 8'h0B, "R4 call raises by two", sp, 8'h0B);
    send(6'b010000, 8'h0, 16'h0, 8'h0); gap(4);
    chk(ret_addr === 16'h1234, "R6 interrupt return address", ret_addr, 16'h1234);
    send(6'b000010, 8'h0, 16'h0, 8'h0); gap(3);
    chk(pop_byte === 8'hB2, "R3 pop order", pop_byte, 8'hB2);
    send(6'b000010, 8'h0, 16'h0, 8'h0); gap(3);
    chk(sp === 8'h07, "R3 back to start", sp, 8'h07);
    send(6'b100000, 8'h0, 16'h0, 8'hFF); gap(2);
    chk(sp === 8'hFF, "R7 load", sp, 8'hFF);
    send(6'b000001, 8'h5A, 16'h0, 8'h0); gap(3);
    chk(sp === 8'h00, "R8 wrap upward", sp, 8'h00);
    send(6'b000010, 8'h0, 16'h0, 8'h0); gap(3);
    chk(sp === 8'hFF && pop_byte === 8'h5A, "R8 wrap downward", {sp, pop_byte}, 16'hFF5A);
    send(6'b100000, 8'h0, 16'h0, 8'hFE); gap(2);
    send(6'b000100, 8'h0, 16'hBEEF, 8'h0); gap(4);
    send(6'b001000, 8'h0, 16'h0, 8'h0); gap(4);
    chk(ret_addr === 16'hBEEF && sp === 8'hFE, "R5 return across wrap",
        {ret_addr, sp}, {16'hBEEF, 8'hFE});
    send(6'b000011, 8'h77, 16'h0, 8'h0); gap(3);
    chk(sp === 8'hFE, "R10 multi-bit request ignored", sp, 8'hFE);
    send(6'b000100, 8'h0, 16'hCAFE, 8'h0);
    send(6'b000001, 8'h99, 16'h0, 8'h0); gap(4);
    chk(sp === 8'h00, "R10 request while busy ignored", sp, 8'h00);
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op;
      op = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'(1 << $urandom_range(0, 5));
      send(op, 8'($urandom), 16'($urandom), 8'($urandom));
      gap($urandom_range(0, 4));
    end
    gap(6);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R9 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule